// File: doc/BRIEF.md
# Dot-Inversion Column Code Path

This block is the digital front end of a display column driver with a small, even number of channels and 10-bit sub-pixel codes. Codes arrive one per clock on a serial input. A one-hot write token steers each code into a per-channel input register. A load strobe then moves the whole row into the converter-facing registers in a single cycle.

Channels are grouped in neighbouring pairs. Within each pair, the converter with the even index (0, 2, ...) only ever produces negative-polarity levels, and the converter with the odd index only ever produces positive-polarity levels. Depending on the line polarity captured at the load strobe, each pair either passes its two codes straight through or exchanges them. A matching output-routing select tells the buffer switches which data line each converter drives.

For every converter, the block emits three things:
- an 8-bit segment index into a 256-segment reference ladder, where segment s lies between taps s and s+1;
- three fine capacitor selects;
- a registered precharge/evaluate phase sequence with a one-cycle done flag.

The extra unit capacitor is wired to the near tap by construction: tap s for positive converters and tap s+1 for negative ones.

Top module: `coldp`

## Requirements
- R1: Each din_valid cycle writes din into the input register marked by the token. The token starts at channel 0 after reset and after every load, and advances by one per write, wrapping from channel NCH-1 back to 0.
- R2: seg_idx, cap_hi and route_sel change only in the cycle after a load. A load captures the input registers as they stood before that cycle's write. Writes and all other inputs between loads leave these outputs unchanged.
- R3: route_sel takes the value of pol sampled at the load. When pol=0, converter c uses channel c's code. When pol=1, converters 2p and 2p+1 exchange the codes of channels 2p and 2p+1.
- R4: An odd (positive) converter with code bits b9..b3 = C outputs a segment index (seg_idx field) of 128+C.
- R5: An even (negative) converter with code bits b9..b3 = C outputs a segment index (seg_idx field) of 127-C.
- R6: cap_hi bit k set means capacitor k precharges to the higher tap s+1. For a positive converter, cap_hi equals code bits b2..b0. For a negative converter, it equals their inverse.
- R7: After a load, precharge is high for max(pre_cycles,1) cycles. Evaluate is then high until the next load. The two phases are never high together.
- R8: done is a single-cycle pulse in the cycle after evaluate first goes high.
- R9: After reset the outputs equal a latched all-zero row with pol=0:
  - segment index 127 (even) and 128 (odd);
  - cap_hi 7 (even) and 0 (odd);
  - route_sel, precharge, evaluate and done all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | CW | Serial sub-pixel code |
| din_valid | input | 1 | Write din at the token position |
| load | input | 1 | Row transfer strobe |
| pol | input | 1 | Line polarity, sampled at load (1 = exchange) |
| pre_cycles | input | PW | Precharge length in cycles (0 treated as 1) |
| seg_idx | output | NCH*8 | Ladder segment index per converter |
| cap_hi | output | NCH*FW | Fine capacitor upper-tap selects per converter |
| route_sel | output | 1 | Output-routing exchange select |
| precharge | output | 1 | Precharge phase control |
| evaluate | output | 1 | Evaluate phase control |
| done | output | 1 | Conversion-done pulse |

## Verification
The checker watches several properties on every cycle:
- the precharge and evaluate phases are mutually exclusive;
- precharge starts right after a load;
- done follows the rise of evaluate and only occurs while evaluate is held;
- the row outputs hold between loads;
- route_sel follows the sampled pol;
- each converter's segment index stays in its own half of the ladder.

Some behaviours can only be shown by the bench's scenarios, since they need a reference model of the row:
- the exact codes routed under each polarity;
- the segment and fine-select arithmetic;
- token wrap and the token restart on load;
- the precharge length for different settings.

// File: rtl/coldp.sv
module coldp #(
  parameter int NCH = 4,
  parameter int CW  = 10,
  parameter int FW  = 3,
  parameter int PW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     din,
  input  logic              din_valid,
  input  logic              load,
  input  logic              pol,
  input  logic [PW-1:0]     pre_cycles,
  output logic [NCH*8-1:0]  seg_idx,
  output logic [NCH*FW-1:0] cap_hi,
  output logic              route_sel,
  output logic              precharge,
  output logic              evaluate,
  output logic              done
);
  localparam int CCW  = CW - FW;
  localparam int HALF = 1 << CCW;
  localparam int NPR  = NCH / 2;

  logic [NCH-1:0] token;
  logic [CW-1:0]  inreg [NCH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         token <= NCH'(1);
    else if (load)      token <= NCH'(1);
    else if (din_valid) token <= {token[NCH-2:0], token[NCH-1]};

  for (genvar c = 0; c < NCH; c++) begin : g_in
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      inreg[c] <= '0;
      else if (din_valid && token[c])  inreg[c] <= din;
  end

  for (genvar p = 0; p < NPR; p++) begin : g_pair
    logic [CW-1:0] neg_code, pos_code;
    assign neg_code = pol ? inreg[2*p+1] : inreg[2*p];
    assign pos_code = pol ? inreg[2*p]   : inreg[2*p+1];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        seg_idx[(2*p)*8 +: 8]     <= 8'(HALF - 1);
        cap_hi[(2*p)*FW +: FW]    <= '1;
        seg_idx[(2*p+1)*8 +: 8]   <= 8'(HALF);
        cap_hi[(2*p+1)*FW +: FW]  <= '0;
      end else if (load) begin
        seg_idx[(2*p)*8 +: 8]     <= 8'(HALF - 1) - 8'(neg_code[CW-1:FW]);
        cap_hi[(2*p)*FW +: FW]    <= ~neg_code[FW-1:0];
        seg_idx[(2*p+1)*8 +: 8]   <= 8'(HALF) + 8'(pos_code[CW-1:FW]);
        cap_hi[(2*p+1)*FW +: FW]  <= pos_code[FW-1:0];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    route_sel <= 1'b0;
    else if (load) route_sel <= pol;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_EVAL} st_t;
  st_t st;
  logic [PW-1:0] cnt;
  logic ev_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (load) begin
      st  <= S_PRE;
      cnt <= (pre_cycles == '0) ? PW'(1) : pre_cycles;
    end else if (st == S_PRE) begin
      if (cnt <= PW'(1)) st <= S_EVAL;
      else               cnt <= cnt - PW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ev_d <= 1'b0;
      done <= 1'b0;
    end else begin
      ev_d <= (st == S_EVAL);
      done <= (st == S_EVAL) && !ev_d;
    end

  assign precharge = (st == S_PRE);
  assign evaluate  = (st == S_EVAL);
endmodule

// File: rtl/coldp_chk.sv
module coldp_chk #(
  parameter int NCH = 4,
  parameter int FW  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              pol,
  input logic [NCH*8-1:0]  seg_idx,
  input logic [NCH*FW-1:0] cap_hi,
  input logic              route_sel,
  input logic              precharge,
  input logic              evaluate,
  input logic              done
);
  // R7
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(precharge && evaluate));
  // R7
  pre_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> precharge);
  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evaluate) |=> done);
  // R8
  done_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(evaluate) && !$past(done));
  // R2
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(seg_idx) && $stable(cap_hi) && $stable(route_sel));
  // R3
  route_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> route_sel == $past(pol));
  for (genvar c = 0; c < NCH; c++) begin : g_rng
    if (c % 2 == 1) begin : g_pos
      // R4
      pos_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_idx[c*8+7]);
    end else begin : g_neg
      // R5
      neg_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_idx[c*8+7]);
    end
  end
endmodule

bind coldp coldp_chk #(.NCH(NCH), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .pol(pol), .seg_idx(seg_idx),
  .cap_hi(cap_hi), .route_sel(route_sel), .precharge(precharge),
  .evaluate(evaluate), .done(done));

// File: tb/test_coldp.sv
module test_coldp;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 10;
  localparam int FW  = 3;
  localparam int PW  = 4;
  localparam int NV  = 6;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 10'd0,    10'd1023, 10'd7,   10'd8},
    {1'b1, 10'd0,    10'd1023, 10'd7,   10'd8},
    {1'b0, 10'h2A5,  10'h15A,  10'h3F0, 10'h00F},
    {1'b1, 10'h2A5,  10'h15A,  10'h3F0, 10'h00F},
    {1'b1, 10'd1023, 10'd1023, 10'd0,   10'd512},
    {1'b0, 10'd511,  10'd512,  10'd100, 10'd900}
  };

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] din = '0;
  logic din_valid = 0, load = 0, pol = 0;
  logic [PW-1:0] pre_cycles = 4'd2;
  logic [NCH*8-1:0] seg_idx;
  logic [NCH*FW-1:0] cap_hi;
  logic route_sel, precharge, evaluate, done;
  int checks = 0, failures = 0;
  logic [CW-1:0] row [NCH];

  coldp #(.NCH(NCH), .CW(CW), .FW(FW), .PW(PW)) i_coldp (
    .clk(clk), .rst_n(rst_n), .din(din), .din_valid(din_valid), .load(load),
    .pol(pol), .pre_cycles(pre_cycles), .seg_idx(seg_idx), .cap_hi(cap_hi),
    .route_sel(route_sel), .precharge(precharge), .evaluate(evaluate), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic put(input logic [CW-1:0] code);
    din = code; din_valid = 1; tick(); din_valid = 0;
  endtask

  task automatic do_load(input logic p);
    load = 1; pol = p; tick(); load = 0;
  endtask

  task automatic check_row(input logic p, input string tag);
    for (int c = 0; c < NCH; c++) begin
      logic [CW-1:0] src;
      int eseg, ecap;
      src = p ? row[c ^ 1] : row[c];
      if (c % 2 == 1) begin
        eseg = 128 + int'(src[CW-1:FW]);
        ecap = int'(src[FW-1:0]);
        chk(int'(seg_idx[c*8 +: 8]), eseg, {tag, " R4 R3 seg"});
        chk(int'(cap_hi[c*FW +: FW]), ecap, {tag, " R6 cap"});
      end else begin
        eseg = 127 - int'(src[CW-1:FW]);
        ecap = int'(~src[FW-1:0]) & 7;
        chk(int'(seg_idx[c*8 +: 8]), eseg, {tag, " R5 R3 seg"});
        chk(int'(cap_hi[c*FW +: FW]), ecap, {tag, " R6 cap"});
      end
    end
    chk(int'(route_sel), int'(p), {tag, " R3 route"});
  endtask

  task automatic check_phases(input int n);
    for (int i = 0; i < n; i++) begin
      chk(int'(precharge), 1, "R7 precharge");
      chk(int'(evaluate), 0, "R7 no eval in precharge");
      tick();
    end
    chk(int'(evaluate), 1, "R7 evaluate");
    chk(int'(precharge), 0, "R7 precharge off");
    chk(int'(done), 0, "R8 done not yet");
    tick();
    chk(int'(done), 1, "R8 done pulse");
    tick();
    chk(int'(done), 0, "R8 done single");
    chk(int'(evaluate), 1, "R7 evaluate held");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) row[c] = '0;
    tick(); tick();
    // R9 reset state
    check_row(1'b0, "R9");
    chk(int'(precharge), 0, "R9 precharge");
    chk(int'(evaluate), 0, "R9 evaluate");
    chk(int'(done), 0, "R9 done");
    rst_n = 1; tick();

    // R1 table walk
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < NCH; c++) begin
        row[c] = VEC[v][(NCH-1-c)*CW +: CW];
        put(row[c]);
      end
      do_load(VEC[v][40]);
      check_row(VEC[v][40], "R1 table");
      check_phases(2);
    end

    // R7 pre_cycles = 0 acts as 1, and 5
    pre_cycles = 4'd0; do_load(1'b0); check_phases(1);
    pre_cycles = 4'd5; do_load(1'b1); check_phases(5);

    // R10-style: pol and writes between loads are ignored (R2)
    pol = 1'b0; put(10'd333); pol = 1'b1; tick(); tick();
    check_row(1'b1, "R2 hold");
    do_load(1'b0);
    row[0] = 10'd333;
    check_row(1'b0, "R2 capture");

    // R1 token restart on load: write two, load, then write one
    put(10'd900); put(10'd17);
    row[0] = 10'd900; row[1] = 10'd17;
    do_load(1'b0);
    check_row(1'b0, "R1 partial");
    put(10'd44);
    row[0] = 10'd44;
    do_load(1'b1);
    check_row(1'b1, "R1 restart");

    // R1 wrap: five writes, fifth lands on channel 0
    for (int c = 0; c < NCH; c++) begin row[c] = CW'(c * 200 + 3); put(row[c]); end
    put(10'd1000); row[0] = 10'd1000;
    do_load(1'b0);
    check_row(1'b0, "R1 wrap");

    // R2 load with concurrent write captures old value
    din = 10'd555; din_valid = 1; load = 1; pol = 1; tick();
    din_valid = 0; load = 0;
    check_row(1'b1, "R2 same-cycle");
    do_load(1'b0);
    row[0] = 10'd555;
    check_row(1'b0, "R2 written");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule